// File: doc/BRIEF.md
# Power Button Conditioner with Hold Override

This block sits between a noisy, active-low power button pin and the power management logic. The raw pin is first synchronized to the system clock. It then goes through a level filter driven by a one-millisecond tick. The filter moves its output only after the synchronized input has disagreed with it for a fixed number of consecutive ticks. The filter treats presses and releases in the same way, so glitches shorter than 12 ms are dropped and levels of 16 ms or more always get through.

A filtered press does two things. It sets a sticky button status bit, and if the system is not fully on it issues a one-cycle wake request. If the filtered button stays pressed for four seconds while the system is in any state other than soft-off, an override event fires. The event sets a sticky override status bit and forces the active-low power-on output inactive. The force stays in place until the power state reaches soft-off and a new filtered press is seen there. Software clears either status bit by pulsing its clear input.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: A raw level, pressed or released, that lasts 11 ms of ticks or less never changes `btn_level`.
- R2: A raw level held for 16 ticks or more always appears on `btn_level` (1 = pressed, raw pin low = pressed); `btn_level` only changes in a cycle that follows a tick.
- R3: The filter applies the same thresholds to release as to press: a short release glitch during a held press leaves `btn_level` at 1, and a long release returns it to 0.
- R4: Each filtered press (a 0 to 1 change of `btn_level`) sets `btn_sts`.
- R5: A filtered press while `pwr_state` is not 0 (0 = fully on) produces one pulse on `wake_req`; a press while `pwr_state` is 0 produces none.
- R6: When `btn_level` has been 1 for `HOLD_TICKS` ticks (default 4000, four seconds) and `pwr_state` is not 5 (5 = soft-off), exactly one override event occurs per continuous hold.
- R7: An override event sets `ovr_sts` and drives `pwron_n` to 1.
- R8: `btn_sts` and `ovr_sts` stay set until a cycle with the matching clear input at 1; if a set and a clear coincide, the bit stays set.
- R9: No override event occurs while `pwr_state` is 5, however long the press lasts.
- R10: After an override, `pwron_n` stays 1 in every power state until a filtered press occurs while `pwr_state` is 5; after that, `pwron_n` is 0 whenever `pwr_state` is not 5.
- R11: After reset, `btn_level`, `btn_sts`, `ovr_sts` and `wake_req` are 0, and `pwron_n` is 1 exactly when `pwr_state` is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| btn_raw_n | input | 1 | Raw button pin, low when pressed |
| pwr_state | input | 3 | Current power state: 0 fully on, 5 soft-off, others sleep |
| btn_sts_clr | input | 1 | Clear for the button status bit |
| ovr_sts_clr | input | 1 | Clear for the override status bit |
| btn_level | output | 1 | Filtered button level, 1 = pressed |
| btn_sts | output | 1 | Sticky button status |
| ovr_sts | output | 1 | Sticky override status |
| wake_req | output | 1 | One-cycle request to go to fully on |
| pwron_n | output | 1 | Active-low power-on output |

## Verification
A raw edge takes two clock cycles to cross the synchronizer. The filter then needs 14 ticks of disagreement before `btn_level` moves, on the clock edge of the 14th tick. `btn_sts`, `ovr_sts` and `wake_req` follow one cycle after the event. `pwron_n` follows the force register with no added register. The bench runs each stimulus for a whole number of ticks, then waits three extra cycles on the falling clock edge before it samples. Stimulus widths stay clear of the 12 to 16 ms window edges, so tick alignment cannot change an expected value. Wake pulses are counted across each stimulus phase, and the hold test checks the override status just before and just after the four-second mark.

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl #(
  parameter int STABLE_TICKS = 14,
  parameter int HOLD_TICKS   = 4000,
  parameter int STATE_W      = 3,
  parameter logic [STATE_W-1:0] ST_ON   = 3'd0,
  parameter logic [STATE_W-1:0] ST_SOFF = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic               btn_raw_n,
  input  logic [STATE_W-1:0] pwr_state,
  input  logic               btn_sts_clr,
  input  logic               ovr_sts_clr,
  output logic               btn_level,
  output logic               btn_sts,
  output logic               ovr_sts,
  output logic               wake_req,
  output logic               pwron_n
);
  localparam int SW = $clog2(STABLE_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STABLE_TICKS - 1);
  localparam logic [HW-1:0] H_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [HW-1:0] H_MAX  = HW'(HOLD_TICKS);

  logic [1:0]    sync;
  logic [SW-1:0] stab_cnt;
  logic [HW-1:0] hold_cnt;
  logic          force_off;

  wire pressed_s = ~sync[1];
  wire differs   = pressed_s != btn_level;
  wire flip      = differs && tick_ms && stab_cnt == S_LAST;
  wire press_evt = flip && pressed_s;
  wire in_soff   = pwr_state == ST_SOFF;
  wire ovr_evt   = btn_level && tick_ms && hold_cnt == H_LAST && !in_soff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], btn_raw_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stab_cnt  <= '0;
      btn_level <= 1'b0;
    end else if (!differs) begin
      stab_cnt <= '0;
    end else if (tick_ms) begin
      if (flip) begin
        btn_level <= pressed_s;
        stab_cnt  <= '0;
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          hold_cnt <= '0;
    else if (!btn_level)                 hold_cnt <= '0;
    else if (tick_ms && hold_cnt < H_MAX) hold_cnt <= hold_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      btn_sts   <= 1'b0;
      ovr_sts   <= 1'b0;
      wake_req  <= 1'b0;
      force_off <= 1'b0;
    end else begin
      btn_sts  <= press_evt | (btn_sts & ~btn_sts_clr);
      ovr_sts  <= ovr_evt   | (ovr_sts & ~ovr_sts_clr);
      wake_req <= press_evt && pwr_state != ST_ON;
      if (ovr_evt)                   force_off <= 1'b1;
      else if (press_evt && in_soff) force_off <= 1'b0;
    end

  assign pwron_n = force_off | in_soff;

  p_level_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_level != $past(btn_level)) |-> $past(tick_ms));
  p_btn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_sts && !btn_sts_clr) |=> btn_sts);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sts && !ovr_sts_clr) |=> ovr_sts);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt |=> btn_sts);
  p_hold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= H_MAX);
  p_no_ovr_soff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_soff && !ovr_sts) |=> !$rose(ovr_sts));
  p_force_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_sts) |-> pwron_n);
  p_wake_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(pwr_state) != ST_ON);
endmodule

// File: tb/tb_pwrbtn_ctrl.sv
module tb_pwrbtn_ctrl;
  logic clk = 0, rst_n = 0, tick = 0, raw_n = 1, bclr = 0, oclr = 0;
  logic [2:0] st = 3'd0;
  logic lvl, bsts, osts, wake, pwron_n;
  int errors = 0, checks = 0, wakes = 0;

  always #5 clk = ~clk;

  pwrbtn_ctrl dut (.clk(clk), .rst_n(rst_n), .tick_ms(tick), .btn_raw_n(raw_n),
    .pwr_state(st), .btn_sts_clr(bclr), .ovr_sts_clr(oclr), .btn_level(lvl),
    .btn_sts(bsts), .ovr_sts(osts), .wake_req(wake), .pwron_n(pwron_n));

  always @(posedge clk) if (rst_n && wake) wakes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk) begin bclr = 1; oclr = 1; end
    @(negedge clk) begin bclr = 0; oclr = 0; end
  endtask

  // press width in ticks, expected btn_level at end, expected btn_sts
  localparam int NV = 6;
  localparam int VW[NV]   = '{3, 11, 16, 20, 8, 30};
  localparam bit VLVL[NV] = '{0, 0, 1, 1, 0, 1};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 level", lvl, 0); chk("R11 btn_sts", bsts, 0);
    chk("R11 ovr_sts", osts, 0); chk("R11 wake", wake, 0);
    chk("R11 pwron_n on", pwron_n, 0);
    st = 3'd5; #1 chk("R11 pwron_n soff", pwron_n, 1);
    st = 3'd0;
    @(negedge clk) rst_n = 1;

    // R1 R2 R4 R5: press widths in fully-on state
    for (int v = 0; v < NV; v++) begin
      raw_n = 0;
      ticks(VW[v]);
      chk(VLVL[v] ? "R2 accept press" : "R1 reject press", lvl, VLVL[v]);
      chk("R4 btn_sts", bsts, VLVL[v]);
      raw_n = 1;
      ticks(20);
      chk("R3 release", lvl, 0);
      chk("R5 no wake when on", wakes, 0);
      clr_all();
      chk("R8 clear", bsts, 0);
    end

    // R1/R3: short release glitch while held
    raw_n = 0; ticks(20);
    raw_n = 1; ticks(11);
    chk("R3 release glitch rejected", lvl, 1);
    raw_n = 0; ticks(5);
    raw_n = 1; ticks(20);
    chk("R3 long release", lvl, 0);
    clr_all();

    // R5: press in sleep
    st = 3'd3; wakes = 0;
    raw_n = 0; ticks(20);
    chk("R5 wake in sleep", wakes, 1);
    raw_n = 1; ticks(20);
    chk("R5 single wake", wakes, 1);
    st = 3'd0; clr_all();

    // R6 R7: four second hold in fully-on
    raw_n = 0;
    ticks(3950);
    chk("R6 no early override", osts, 0);
    chk("R7 pwron_n before", pwron_n, 0);
    ticks(150);
    chk("R6 override", osts, 1);
    chk("R7 pwron_n forced", pwron_n, 1);
    clr_all();
    chk("R8 ovr clear", osts, 0);
    ticks(200);
    chk("R6 single override", osts, 0);
    raw_n = 1; ticks(20);
    chk("R10 force held", pwron_n, 1);
    st = 3'd2; #1 chk("R10 force held sleep", pwron_n, 1);

    // R10: release through soft-off press
    st = 3'd5; wakes = 0;
    raw_n = 0; ticks(20);
    raw_n = 1; ticks(20);
    chk("R5 wake from soff", wakes, 1);
    st = 3'd0; #1 chk("R10 force released", pwron_n, 0);
    clr_all();

    // R9: long hold in soft-off
    st = 3'd5;
    raw_n = 0; ticks(4200);
    chk("R9 no override in soff", osts, 0);
    raw_n = 1; ticks(20);
    st = 3'd0; #1 chk("R9 pwron_n", pwron_n, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule